// File: doc/BRIEF.md
# Hardwired Accumulator Processor

This block is a small 8-bit processor built around a single accumulator. It holds a 64-byte memory and runs programs made of four one-byte instructions: load into the accumulator, add to the accumulator, store the accumulator, and unconditional jump. A control unit made only of gates steers the datapath. This control unit uses a two-bit step counter, a step decoder, an opcode decoder and one state bit. The state bit marks whether the core is fetching or executing. The datapath has a program counter, an instruction register, a memory address register, a memory buffer register, the accumulator, and an adder whose result waits in its own buffer register.

The step counter returns to zero on the last step of each phase, so the number of cycles depends on the instruction. Fetch takes three cycles. Execution then takes one to four cycles, depending on the opcode. Memory is filled through a preload write port while the core is held in reset. A separate read port lets the surrounding logic inspect any memory word at any time. The accumulator and the program counter are visible as outputs.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted, the program counter and the accumulator read 0. The first clock after reset is released begins a fetch from address 0.
- R2: An instruction byte carries the opcode in bits 7:6 and the operand address in bits 5:0. The opcode values are 00 load, 01 add, 10 jump and 11 store.
- R3: Every fetch lasts three cycles. The program counter becomes its old value plus one, wrapping modulo 256, at the end of the third fetch cycle and at no other time during fetch. Instruction bytes are read at the low six bits of the program counter.
- R4: A load takes 6 cycles in total. At the end of its sixth cycle, the accumulator takes the memory word at the operand address.
- R5: An add takes 7 cycles in total. At the end of its seventh cycle, the accumulator becomes its old value plus the operand word, modulo 256, with no overflow indication.
- R6: A store takes 5 cycles in total. At the end of its fifth cycle, the accumulator value is written to the operand address.
- R7: A jump takes 4 cycles in total. At the end of its fourth cycle, the program counter takes the operand address, with its two upper bits cleared.
- R8: The accumulator never changes during a fetch, even when the instruction register still holds an add.
- R9: When the preload enable is high, a rising clock edge writes the preload data at the preload address. This also works while reset is asserted, and reset never clears memory contents.
- R10: The debug read port shows, without a clock, the memory word at the debug address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 6 | Preload word address |
| pre_data | input | 8 | Preload word value |
| dbg_addr | input | 6 | Debug read address |
| dbg_data | output | 8 | Memory word at the debug address |
| acc_out | output | 8 | Accumulator |
| pc_out | output | 8 | Program counter |

## Verification
A step counter or state bit that is wrong makes an instruction end a cycle too early or too late. The program counter then moves on the wrong edge, and that shows at the program counter output within the same instruction. Control that ignores the state bit lets a leftover add change the accumulator during the next fetch, and the accumulator output reveals this on that very edge. Address or write-enable faults appear only in memory, so the bench reads memory back through the debug port once each program has settled.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int OP_W    = DATA_W - ADDR_W;
    localparam int STEP_W  = 2;
    localparam int N_STEPS = 1 << STEP_W;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 2'b00,
        OP_ADD   = 2'b01,
        OP_JUMP  = 2'b10,
        OP_STORE = 2'b11
    } opcode_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mbr_from_mem;
        logic mbr_from_ac;
        logic alu_run;
        logic alu_use_acc;
        logic alu_sel_pc;
        logic alu_cin;
        logic pc_from_alu;
        logic pc_from_ir;
        logic ir_load;
        logic ac_from_alu;
        logic ac_from_mbr;
        logic mem_we;
    } ctl_t;
endpackage

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  opcode_e           opcode,
    output logic              fetch,
    output logic [STEP_W-1:0] step,
    output ctl_t              ctl
);
    typedef struct packed {
        logic              fetch;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t d, q;
    logic [N_STEPS-1:0] t;
    logic is_l, is_a, is_j, is_s, last;

    always_comb begin
        t = '0;
        t[q.step] = 1'b1;
        is_l = (opcode == OP_LOAD);
        is_a = (opcode == OP_ADD);
        is_j = (opcode == OP_JUMP);
        is_s = (opcode == OP_STORE);

        // last micro-step of the current phase
        last = q.fetch ? t[2]
                       : ((t[0] & is_j) | (t[1] & is_s) | (t[2] & is_l) | (t[3] & is_a));

        d.step  = last ? '0 : q.step + 1'b1;
        d.fetch = q.fetch ? ~t[2] : last;

        ctl = '0;
        if (q.fetch) begin
            ctl.mar_from_pc  = t[0];
            ctl.mbr_from_mem = t[1];
            ctl.alu_run      = t[1];
            ctl.alu_sel_pc   = t[1];
            ctl.alu_cin      = t[1];
            ctl.pc_from_alu  = t[2];
            ctl.ir_load      = t[2];
        end else begin
            ctl.mar_from_ir  = t[0] & (is_l | is_a | is_s);
            ctl.mbr_from_ac  = t[0] & is_s;
            ctl.pc_from_ir   = t[0] & is_j;
            ctl.mbr_from_mem = t[1] & (is_l | is_a);
            ctl.mem_we       = t[1] & is_s;
            ctl.alu_run      = t[2] & is_a;
            ctl.alu_use_acc  = t[2] & is_a;
            ctl.ac_from_mbr  = t[2] & is_l;
            ctl.ac_from_alu  = t[3] & is_a;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.fetch <= 1'b1;
            q.step  <= '0;
        end else begin
            q <= d;
        end
    end

    assign fetch = q.fetch;
    assign step  = q.step;
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              use_acc,
    input  logic              sel_pc,
    input  logic              cin,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] buf_d, buf_q, op_a, op_b;

    always_comb begin
        op_a  = use_acc ? acc : '0;
        op_b  = sel_pc ? pc : mbr;
        buf_d = run ? (op_a + op_b + {{(DATA_W-1){1'b0}}, cin}) : buf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign result = buf_q;
endmodule

// File: rtl/cpu_mem.sv
module cpu_mem
    import cpu_pkg::*;
(
    input  logic              clk,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (pre_we)      mem_q[pre_addr] <= pre_data;
        else if (cpu_we) mem_q[cpu_addr] <= cpu_wdata;
    end

    assign cpu_rdata = mem_q[cpu_addr];
    assign dbg_data  = mem_q[dbg_addr];
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] pc_out
);
    typedef struct packed {
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ac;
    } regs_t;

    regs_t             d, q;
    ctl_t              ctl;
    opcode_e           opc;
    logic              is_fetch;
    logic [STEP_W-1:0] step_now;
    logic [DATA_W-1:0] alu_res, mem_rd;

    assign opc = opcode_e'(q.ir[DATA_W-1 -: OP_W]);

    cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opc),
        .fetch  (is_fetch),
        .step   (step_now),
        .ctl    (ctl)
    );

    cpu_alu u_alu (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl.alu_run),
        .use_acc (ctl.alu_use_acc),
        .sel_pc  (ctl.alu_sel_pc),
        .cin     (ctl.alu_cin),
        .acc     (q.ac),
        .pc      (q.pc),
        .mbr     (q.mbr),
        .result  (alu_res)
    );

    cpu_mem u_mem (
        .clk       (clk),
        .pre_we    (pre_we),
        .pre_addr  (pre_addr),
        .pre_data  (pre_data),
        .cpu_we    (ctl.mem_we),
        .cpu_addr  (q.mar),
        .cpu_wdata (q.mbr),
        .cpu_rdata (mem_rd),
        .dbg_addr  (dbg_addr),
        .dbg_data  (dbg_data)
    );

    always_comb begin
        d = q;
        if (ctl.mar_from_pc)  d.mar = q.pc[ADDR_W-1:0];
        if (ctl.mar_from_ir)  d.mar = q.ir[ADDR_W-1:0];
        if (ctl.mbr_from_mem) d.mbr = mem_rd;
        if (ctl.mbr_from_ac)  d.mbr = q.ac;
        if (ctl.pc_from_alu)  d.pc  = alu_res;
        if (ctl.pc_from_ir)   d.pc  = {{OP_W{1'b0}}, q.ir[ADDR_W-1:0]};
        if (ctl.ir_load)      d.ir  = q.mbr;
        if (ctl.ac_from_alu)  d.ac  = alu_res;
        if (ctl.ac_from_mbr)  d.ac  = q.mbr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign acc_out = q.ac;
    assign pc_out  = q.pc;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] pc,
    input logic [7:0] ac,
    input logic       fetch,
    input logic [1:0] step,
    input logic [1:0] opcode
);
    AST_FETCH_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && step == 2'd2) |=> (!fetch && step == 2'd0)); // R3

    AST_PC_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && step == 2'd2) |=> (pc == $past(pc) + 8'd1)); // R3

    AST_AC_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> $stable(ac)); // R8

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((fetch && step != 2'd2) || (!fetch && !(step == 2'd0 && opcode == 2'b10)))
        |=> $stable(pc)); // R7

    AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch && opcode == 2'b00 && step == 2'd2) |=> (fetch && step == 2'd0)); // R4

    AST_ADD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch && opcode == 2'b01 && step == 2'd3) |=> (fetch && step == 2'd0)); // R5

    AST_STORE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch && opcode == 2'b11 && step == 2'd1) |=> (fetch && step == 2'd0)); // R6

    AST_EXEC_AC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch && !(opcode == 2'b00 && step == 2'd2) && !(opcode == 2'b01 && step == 2'd3))
        |=> $stable(ac)); // R4
endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc     (pc_out),
    .ac     (acc_out),
    .fetch  (is_fetch),
    .step   (step_now),
    .opcode (opc)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_we = 1'b0;
    logic [5:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic [5:0] dbg_addr = '0;
    logic [7:0] dbg_data, acc_out, pc_out;

    int n_checks = 0;
    int n_fail   = 0;
    int n_cycles = 0;
    bit model_on = 1'b0;

    // behavioural reference
    logic [7:0] ref_mem [64];
    logic [7:0] ref_pc = '0;
    logic [7:0] ref_ac = '0;
    logic [7:0] ref_ins = '0;
    int         ref_k = 0;

    acc_cpu u0 (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
        .acc_out(acc_out), .pc_out(pc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // R2 decoding: op in bits 7:6, address in 5:0
    always @(posedge clk) begin
        n_cycles++;
        if (!rst_n) begin
            ref_pc = '0; ref_ac = '0; ref_k = 0;
        end else begin
            logic [1:0] op;
            logic [5:0] a;
            ref_k++;
            if (ref_k == 1) ref_ins = ref_mem[ref_pc[5:0]];
            if (ref_k == 3) ref_pc = ref_pc + 8'd1;
            op = ref_ins[7:6];
            a  = ref_ins[5:0];
            case (op)
                2'b00: if (ref_k == 6) begin ref_ac = ref_mem[a]; ref_k = 0; end
                2'b01: if (ref_k == 7) begin ref_ac = ref_ac + ref_mem[a]; ref_k = 0; end
                2'b11: if (ref_k == 5) begin ref_mem[a] = ref_ac; ref_k = 0; end
                default: if (ref_k == 4) begin ref_pc = {2'b00, a}; ref_k = 0; end
            endcase
        end
        if (n_cycles > WATCHDOG) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check("R3 R7 pc", pc_out, ref_pc);
            check("R4 R5 R8 ac", acc_out, ref_ac);
        end
    end

    task automatic preload(input logic [5:0] a, input logic [7:0] v);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = v;
        ref_mem[a] = v;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic peek(input string req, input logic [5:0] a, input logic [7:0] exp);
        @(negedge clk);
        dbg_addr = a;
        #1;
        check(req, dbg_data, exp);
    endtask

    task automatic run(input int cycles);
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_on = 1'b0;
        @(negedge clk);
        check("R1 pc in reset", pc_out, 8'h00);
        check("R1 ac in reset", acc_out, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        for (int i = 0; i < 64; i++) preload(i[5:0], 8'h00);
        check("R1 pc in reset", pc_out, 8'h00);
        check("R1 ac in reset", acc_out, 8'h00);

        // program 1: sum four words, wrap modulo 256
        preload(6'd0, 8'h0A);  // load 10
        preload(6'd1, 8'h4B);  // add 11
        preload(6'd2, 8'h4C);  // add 12
        preload(6'd3, 8'h4D);  // add 13
        preload(6'd4, 8'hCE);  // store 14
        preload(6'd5, 8'h85);  // jump 5
        preload(6'd10, 8'h30);
        preload(6'd11, 8'h55);
        preload(6'd12, 8'h70);
        preload(6'd13, 8'h9A);
        peek("R9 R10 preload visible", 6'd13, 8'h9A);
        check("R1 pc still reset after preload", pc_out, 8'h00);

        run(60);
        peek("R6 sum stored", 6'd14, 8'h8F);
        peek("R6 operand intact", 6'd10, 8'h30);
        check("R5 final ac", acc_out, 8'h8F);
        check("R7 pc parked at jump", pc_out, 8'h05);

        hold_reset();
        peek("R9 memory kept over reset", 6'd14, 8'h8F);

        // program 2: store then add, jump over a skipped add
        preload(6'd0, 8'h14);  // load 20
        preload(6'd1, 8'hD5);  // store 21
        preload(6'd2, 8'h55);  // add 21
        preload(6'd3, 8'h86);  // jump 6
        preload(6'd4, 8'h54);  // add 20 (skipped)
        preload(6'd6, 8'hD6);  // store 22
        preload(6'd7, 8'h87);  // jump 7
        preload(6'd20, 8'hC8);
        preload(6'd21, 8'h00);
        preload(6'd22, 8'h00);

        run(70);
        peek("R6 store of loaded word", 6'd21, 8'hC8);
        peek("R6 store of wrapped sum", 6'd22, 8'h90);
        check("R5 wrapped ac", acc_out, 8'h90);
        check("R7 pc parked", pc_out, 8'h07);

        hold_reset();
        report();
    end
endmodule